// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Handler

This block is the addressing layer of a slave on a single-wire, open-drain, multidrop bus. A bit-level slot interface sits in front of it. That interface turns the analog waveform into three one-cycle events: a bus reset, a write slot carrying one bit, and a read slot in which the slave may pull the line. Every slot starts when the master pulls the line low, and the slot interface uses that falling edge to synchronise. The handler holds a 64-bit identity code. Bits 7:0 are the family code, bits 55:8 the serial number and bits 63:56 the check byte. The handler answers every bus reset with a presence request.

After a reset the first byte the master writes is taken as an addressing command:

- **33h** sends out the identity.
- **55h** selects the device by comparing an identity sent by the master.
- **F0h** joins a bit-by-bit binary search among all devices on the bus.
- **A5h** resumes the device that was selected last, without sending its identity again.

A device that wins addressing hands control to a downstream function layer through `fn_start` and `fn_active`. A device that loses stays silent until the next bus reset.

The identity input must be held stable during operation. While the handler owns a read slot, `tx_bit` gives the level to drive: 0 pulls the line low and 1 releases it. While `tx_en` is low, the slot layer must leave the line released.

Top module: `owr_rom_ctrl`

## Requirements
- R1: After `rst_n` is released, the block ignores write slots and read slots until the first bus reset event. `presence_req`, `tx_en`, `fn_start` and `fn_active` all stay 0.
- R2: A bus reset event in any state raises `presence_req` for exactly the one cycle after the event and returns the block to command reception with the bit position cleared.
- R3: The command byte is collected from 8 write slots, least significant bit first. During command reception `tx_en` stays 0 and read slots have no effect.
- R4: Command 33h makes the block own the next 64 read slots, delivering `id_code[0]` first through `id_code[63]` last. After the 64th slot it enters the function layer.
- R5: Command 55h compares the next 64 written bits, least significant first, with `id_code`. A full match enters the function layer and sets the resume flag. The first mismatch makes the block inactive until the next bus reset.
- R6: For command F0h, each identity bit in turn is handled in three slots: the block sends the bit in one read slot, sends its complement in the next read slot, then compares the bit the master writes. A mismatch makes the block inactive until the next bus reset. Surviving all 64 bits enters the function layer and sets the resume flag.
- R7: Command A5h with the resume flag set enters the function layer directly after the command byte. With the flag clear, the block becomes inactive until the next bus reset.
- R8: Receiving 55h or F0h clears the resume flag, so only a selection of this device sets it again. Bus reset events leave the flag unchanged. Only `rst_n` clears it otherwise.
- R9: Any command byte other than 33h, 55h, F0h and A5h makes the block inactive: `tx_en` stays 0 and later slots are ignored until the next bus reset.
- R10: Entering the function layer pulses `fn_start` for one cycle and holds `fn_active` at 1 until the next bus reset. While `fn_active` is 1, `tx_en` stays 0 and slot events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_code | input | 64 | Identity code; bit 0 is sent first |
| evt_reset | input | 1 | One-cycle pulse: bus reset detected |
| evt_wbit | input | 1 | One-cycle pulse: master wrote a bit |
| wbit_val | input | 1 | Value of the written bit, valid with `evt_wbit` |
| evt_rslot | input | 1 | One-cycle pulse: a read slot is being served |
| presence_req | output | 1 | Request to the slot layer to emit a presence pulse |
| tx_en | output | 1 | The block owns the current read slot |
| tx_bit | output | 1 | Level for an owned read slot (0 pulls low) |
| fn_start | output | 1 | One-cycle pulse when control passes to the function layer |
| fn_active | output | 1 | The function layer owns the bus until the next bus reset |

## Verification
The hardest situations to reach are a search that is lost only at the final identity bit, and a resume attempt made after this device lost an arbitration it had entered. Reaching them needs long exact slot sequences: 192 search slots, followed by a fresh reset and the resume command. The stimulus builds the search path by taking the identity and inverting only bit 63. It then issues A5h right after that lost search, and again after a successful search followed by two bus resets. This shows both that the flag is cleared by F0h and that it survives bus resets.

// File: rtl/owr_pkg.sv
package owr_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SEARCH,
        ST_FUNC,
        ST_DEAD
    } rom_st_e;

    typedef enum logic [1:0] {
        SP_TRUE,
        SP_CMPL,
        SP_PICK
    } srch_ph_e;

    typedef enum logic [2:0] {
        CK_READ,
        CK_MATCH,
        CK_SEARCH,
        CK_RESUME,
        CK_BAD
    } cmd_kind_e;

endpackage

// File: rtl/owr_cmd_decode.sv
module owr_cmd_decode
    import owr_pkg::*;
#(
    parameter int          CMD_W      = 8,
    parameter logic [CMD_W-1:0] CODE_READ  = 8'h33,
    parameter logic [CMD_W-1:0] CODE_MATCH = 8'h55,
    parameter logic [CMD_W-1:0] CODE_SRCH  = 8'hF0,
    parameter logic [CMD_W-1:0] CODE_RESUM = 8'hA5
) (
    input  logic [CMD_W-1:0] byte_i,
    output cmd_kind_e        kind_o
);

    always_comb begin
        if (byte_i == CODE_READ)       kind_o = CK_READ;
        else if (byte_i == CODE_MATCH) kind_o = CK_MATCH;
        else if (byte_i == CODE_SRCH)  kind_o = CK_SEARCH;
        else if (byte_i == CODE_RESUM) kind_o = CK_RESUME;
        else                           kind_o = CK_BAD;
    end

endmodule

// File: rtl/owr_id_mux.sv
module owr_id_mux #(
    parameter int ID_W  = 64,
    localparam int IDX_W = $clog2(ID_W)
) (
    input  logic [ID_W-1:0]  id_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             mbit_i,
    output logic             bit_o,
    output logic             eq_o,
    output logic             last_o
);

    assign bit_o  = id_i[idx_i];
    assign eq_o   = (mbit_i == bit_o);
    assign last_o = (idx_i == IDX_W'(ID_W - 1));

endmodule

// File: rtl/owr_rom_ctrl.sv
module owr_rom_ctrl
    import owr_pkg::*;
#(
    parameter int ID_W  = 64,
    parameter int CMD_W = 8,
    parameter logic [CMD_W-1:0] CODE_READ  = 8'h33,
    parameter logic [CMD_W-1:0] CODE_MATCH = 8'h55,
    parameter logic [CMD_W-1:0] CODE_SRCH  = 8'hF0,
    parameter logic [CMD_W-1:0] CODE_RESUM = 8'hA5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] id_code,
    input  logic            evt_reset,
    input  logic            evt_wbit,
    input  logic            wbit_val,
    input  logic            evt_rslot,
    output logic            presence_req,
    output logic            tx_en,
    output logic            tx_bit,
    output logic            fn_start,
    output logic            fn_active
);

    localparam int IDX_W = $clog2(ID_W);
    localparam int CNT_W = $clog2(CMD_W);

    typedef struct packed {
        rom_st_e           st;
        srch_ph_e          ph;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cbit;
        logic [CMD_W-1:0]  sh;
        logic              resume;
        logic              pres;
        logic              fstart;
    } regs_t;

    regs_t r_q, r_d;

    logic [CMD_W-1:0] byte_full;
    cmd_kind_e        kind;
    logic             id_bit, id_eq, id_last;

    // byte as it will stand once the current write slot is shifted in
    assign byte_full = {wbit_val, r_q.sh[CMD_W-1:1]};

    owr_cmd_decode #(
        .CMD_W      (CMD_W),
        .CODE_READ  (CODE_READ),
        .CODE_MATCH (CODE_MATCH),
        .CODE_SRCH  (CODE_SRCH),
        .CODE_RESUM (CODE_RESUM)
    ) dec_i (
        .byte_i (byte_full),
        .kind_o (kind)
    );

    owr_id_mux #(
        .ID_W (ID_W)
    ) mux_i (
        .id_i   (id_code),
        .idx_i  (r_q.idx),
        .mbit_i (wbit_val),
        .bit_o  (id_bit),
        .eq_o   (id_eq),
        .last_o (id_last)
    );

    always_comb begin
        r_d        = r_q;
        r_d.pres   = 1'b0;
        r_d.fstart = 1'b0;
        if (evt_reset) begin
            r_d.st   = ST_CMD;
            r_d.ph   = SP_TRUE;
            r_d.idx  = '0;
            r_d.cbit = '0;
            r_d.sh   = '0;
            r_d.pres = 1'b1;
        end else begin
            case (r_q.st)
                ST_CMD: begin
                    if (evt_wbit) begin
                        r_d.sh   = byte_full;
                        r_d.cbit = r_q.cbit + 1'b1;
                        if (r_q.cbit == CNT_W'(CMD_W - 1)) begin
                            r_d.cbit = '0;
                            r_d.idx  = '0;
                            r_d.ph   = SP_TRUE;
                            case (kind)
                                CK_READ:   r_d.st = ST_READ;
                                CK_MATCH: begin
                                    r_d.st     = ST_MATCH;
                                    r_d.resume = 1'b0;
                                end
                                CK_SEARCH: begin
                                    r_d.st     = ST_SEARCH;
                                    r_d.resume = 1'b0;
                                end
                                CK_RESUME: begin
                                    if (r_q.resume) begin
                                        r_d.st     = ST_FUNC;
                                        r_d.fstart = 1'b1;
                                    end else begin
                                        r_d.st = ST_DEAD;
                                    end
                                end
                                default:   r_d.st = ST_DEAD;
                            endcase
                        end
                    end
                end
                ST_READ: begin
                    if (evt_rslot) begin
                        if (id_last) begin
                            r_d.st     = ST_FUNC;
                            r_d.fstart = 1'b1;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                ST_MATCH: begin
                    if (evt_wbit) begin
                        if (!id_eq) begin
                            r_d.st = ST_DEAD;
                        end else if (id_last) begin
                            r_d.st     = ST_FUNC;
                            r_d.fstart = 1'b1;
                            r_d.resume = 1'b1;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                ST_SEARCH: begin
                    case (r_q.ph)
                        SP_TRUE: if (evt_rslot) r_d.ph = SP_CMPL;
                        SP_CMPL: if (evt_rslot) r_d.ph = SP_PICK;
                        default: begin
                            if (evt_wbit) begin
                                if (!id_eq) begin
                                    r_d.st = ST_DEAD;
                                end else if (id_last) begin
                                    r_d.st     = ST_FUNC;
                                    r_d.fstart = 1'b1;
                                    r_d.resume = 1'b1;
                                end else begin
                                    r_d.idx = r_q.idx + 1'b1;
                                    r_d.ph  = SP_TRUE;
                                end
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_WAIT, ph: SP_TRUE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        tx_en  = (r_q.st == ST_READ) ||
                 ((r_q.st == ST_SEARCH) && (r_q.ph != SP_PICK));
        tx_bit = 1'b1;
        if (tx_en) begin
            tx_bit = ((r_q.st == ST_SEARCH) && (r_q.ph == SP_CMPL)) ? ~id_bit : id_bit;
        end
    end

    assign presence_req = r_q.pres;
    assign fn_start     = r_q.fstart;
    assign fn_active    = (r_q.st == ST_FUNC);

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) |-> (!tx_en && !presence_req && !fn_active)); // R1
    AST_PRES_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_reset |=> (presence_req && r_q.st == ST_CMD && r_q.cbit == '0)); // R2
    AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CMD) |-> !tx_en); // R3
    AST_SRCH_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEARCH && r_q.ph == SP_TRUE && evt_rslot && !evt_reset)
        |=> (tx_en && tx_bit != $past(tx_bit))); // R6
    AST_DEAD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEAD && !evt_reset) |=> (r_q.st == ST_DEAD && !tx_en)); // R9
    AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_active && !evt_reset) |=> (fn_active && !tx_en)); // R10
    AST_FSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fn_start |=> !fn_start); // R10

endmodule

// File: tb/owr_rom_ctrl_tb.sv
`timescale 1ns/1ps
module owr_rom_ctrl_tb_top;

    localparam logic [63:0] ID = {8'hC4, 48'h5A3C_9E17_0B62, 8'h33};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_reset = 1'b0, evt_wbit = 1'b0, wbit_val = 1'b0, evt_rslot = 1'b0;
    logic presence_req, tx_en, tx_bit, fn_start, fn_active;

    int checks = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    owr_rom_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .id_code (ID),
        .evt_reset (evt_reset), .evt_wbit (evt_wbit), .wbit_val (wbit_val),
        .evt_rslot (evt_rslot), .presence_req (presence_req), .tx_en (tx_en),
        .tx_bit (tx_bit), .fn_start (fn_start), .fn_active (fn_active)
    );

    // behavioural reference: 0 wait, 1 cmd, 2 read, 3 match, 4 search, 5 func, 6 dead
    int m_st = 0, m_cnt = 0, m_byte = 0, m_idx = 0, m_ph = 0;
    bit m_res = 0, m_pres = 0, m_fs = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_res = 0; m_pres = 0; m_fs = 0;
        end else begin
            m_pres = 0; m_fs = 0;
            if (evt_reset) begin
                m_st = 1; m_cnt = 0; m_byte = 0; m_idx = 0; m_ph = 0; m_pres = 1;
            end else if (m_st == 1 && evt_wbit) begin
                m_byte = m_byte | (int'(wbit_val) << m_cnt);
                m_cnt++;
                if (m_cnt == 8) begin
                    m_idx = 0; m_ph = 0;
                    if (m_byte == 'h33) m_st = 2;
                    else if (m_byte == 'h55) begin m_st = 3; m_res = 0; end
                    else if (m_byte == 'hF0) begin m_st = 4; m_res = 0; end
                    else if (m_byte == 'hA5) begin
                        if (m_res) begin m_st = 5; m_fs = 1; end else m_st = 6;
                    end else m_st = 6;
                end
            end else if (m_st == 2 && evt_rslot) begin
                m_idx++;
                if (m_idx == 64) begin m_st = 5; m_fs = 1; end
            end else if (m_st == 3 && evt_wbit) begin
                if (wbit_val != ID[m_idx]) m_st = 6;
                else begin
                    m_idx++;
                    if (m_idx == 64) begin m_st = 5; m_fs = 1; m_res = 1; end
                end
            end else if (m_st == 4) begin
                if (m_ph < 2 && evt_rslot) m_ph++;
                else if (m_ph == 2 && evt_wbit) begin
                    if (wbit_val != ID[m_idx]) m_st = 6;
                    else begin
                        m_idx++; m_ph = 0;
                        if (m_idx == 64) begin m_st = 5; m_fs = 1; m_res = 1; end
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(posedge clk) begin
        #1;
        begin
            logic e_en, e_bit;
            e_en  = (m_st == 2) || (m_st == 4 && m_ph < 2);
            e_bit = (m_st == 4 && m_ph == 1) ? ~ID[m_idx % 64] : ID[m_idx % 64];
            chk(cur_req, "presence_req", presence_req, m_pres);
            chk(cur_req, "fn_start", fn_start, m_fs);
            chk(cur_req, "fn_active", fn_active, (m_st == 5));
            chk(cur_req, "tx_en", tx_en, e_en);
            if (e_en) chk(cur_req, "tx_bit", tx_bit, e_bit);
        end
    end

    task automatic bus_reset();
        @(negedge clk); evt_reset = 1'b1;
        @(negedge clk); evt_reset = 1'b0;
        chk("R2", "presence one cycle after reset", presence_req, 1'b1);
        @(negedge clk);
        chk("R2", "presence drops", presence_req, 1'b0);
    endtask

    task automatic wr(input logic b);
        @(negedge clk); evt_wbit = 1'b1; wbit_val = b;
        @(negedge clk); evt_wbit = 1'b0; wbit_val = 1'b0;
    endtask

    task automatic rd(output logic en, output logic b);
        @(negedge clk); evt_rslot = 1'b1; en = tx_en; b = tx_bit;
        @(negedge clk); evt_rslot = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr(v[i]);
    endtask

    task automatic search(input logic [63:0] path, input bit expect_alive);
        logic en, b;
        bit alive;
        alive = 1;
        for (int i = 0; i < 64; i++) begin
            rd(en, b);
            if (alive) chk("R6", "search true bit", b, ID[i]);
            rd(en, b);
            if (alive) chk("R6", "search complement bit", b, ~ID[i]);
            if (!alive) chk("R6", "lost device silent", en, 1'b0);
            wr(path[i]);
            if (path[i] != ID[i]) alive = 0;
        end
        chk("R6", "search outcome", fn_active, expect_alive);
    endtask

    initial begin
        logic en, b;
        logic [63:0] got;
        #100000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic en, b;
        logic [63:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet before first bus reset
        cur_req = "R1";
        chk("R1", "presence after rst_n", presence_req, 1'b0);
        wr_byte(8'h33);
        rd(en, b);
        chk("R1", "tx_en before first reset", en, 1'b0);
        chk("R1", "fn_active before first reset", fn_active, 1'b0);

        // R3: read slots during command reception are ignored
        cur_req = "R3";
        bus_reset();
        rd(en, b);
        chk("R3", "tx_en during command", en, 1'b0);

        // R4: read identity
        cur_req = "R4";
        wr_byte(8'h33);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            rd(en, b);
            got[i] = b;
            if (i == 0) chk("R4", "tx_en in read", en, 1'b1);
        end
        checks++;
        if (got !== ID) begin
            bad++;
            $display("FAIL R4 identity: actual=%h expected=%h", got, ID);
        end
        chk("R10", "fn_active after read", fn_active, 1'b1);
        cur_req = "R10";
        wr(1'b0);
        rd(en, b);
        chk("R10", "slots ignored in function", en, 1'b0);
        chk("R10", "fn_active held", fn_active, 1'b1);

        // R2: reset mid identity read restarts from bit 0
        cur_req = "R2";
        bus_reset();
        wr_byte(8'h33);
        for (int i = 0; i < 10; i++) rd(en, b);
        bus_reset();
        chk("R2", "fn_active cleared by reset", fn_active, 1'b0);
        wr_byte(8'h33);
        rd(en, b);
        chk("R2", "restart at bit 0", b, ID[0]);

        // R5: match success, then R7 resume
        cur_req = "R5";
        bus_reset();
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr(ID[i]);
        chk("R5", "match selects", fn_active, 1'b1);
        cur_req = "R7";
        bus_reset();
        wr_byte(8'hA5);
        chk("R7", "resume after match", fn_active, 1'b1);

        // R5 mismatch at bit 40, then R8 resume refused
        cur_req = "R5";
        bus_reset();
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr((i == 40) ? ~ID[i] : ID[i]);
        chk("R5", "mismatch not selected", fn_active, 1'b0);
        rd(en, b);
        chk("R5", "mismatch silent", en, 1'b0);
        cur_req = "R8";
        bus_reset();
        wr_byte(8'hA5);
        chk("R8", "resume cleared by match cmd", fn_active, 1'b0);

        // R6: search success, R8 resume survives two resets
        cur_req = "R6";
        bus_reset();
        wr_byte(8'hF0);
        search(ID, 1);
        cur_req = "R8";
        bus_reset();
        bus_reset();
        wr_byte(8'hA5);
        chk("R8", "resume survives reset", fn_active, 1'b1);

        // R6: search lost at last bit, R8 resume refused
        cur_req = "R6";
        bus_reset();
        wr_byte(8'hF0);
        search(ID ^ (64'h1 << 63), 0);
        cur_req = "R8";
        bus_reset();
        wr_byte(8'hA5);
        chk("R8", "resume cleared by search cmd", fn_active, 1'b0);

        // R9: unknown command
        cur_req = "R9";
        bus_reset();
        wr_byte(8'hCC);
        wr_byte(8'h33);
        rd(en, b);
        chk("R9", "unknown cmd silent", en, 1'b0);
        chk("R9", "unknown cmd no function", fn_active, 1'b0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule